// File: doc/BRIEF.md
# Command Stream Register Decoder

This block sits behind a byte-wide command FIFO and turns register-load commands into writes to a small bank of copy-setup registers. A load command is a single opcode byte followed by a 32-bit word sent as four bytes, most significant byte first. The top byte of that word selects a register and the low 24 bits are the value. The decoder assembles the word, issues one internal write strobe and updates the addressed register. Bytes that do not begin a valid command are flagged and thrown away.

The bank holds a source origin, a source size, a destination address, a destination stride, a copy-control word and four filter coefficient words. A write to the copy-control register that sets both start bits raises a start request toward a downstream copy engine. If that engine reports busy, the request is held and the input stream is stalled until the engine frees up. A separate combinational port lets any register be read back by index.

Top module: `cmd_regdec`

## Requirements
- R1: After reset the four filter registers (indices 0x01 to 0x04) read 0x666666, every other register reads 0, `in_ready` is 1, and `start_pulse`, `err_unknown` and `clr_en` are 0.
- R2: The byte 0x61 accepted while idle starts a load command. The next four accepted bytes form a 32-bit word, first byte in bits 31:24. Bits 31:24 select the register and bits 23:0 are written to it. The new value reads back on `rd_data` two clock edges after the last byte is accepted.
- R3: Index 0x49 (source origin), 0x4A (source size) and 0x4B (destination address) store all 24 bits. Index 0x4D (destination stride) stores bits 9:0, and its bits 23:10 read 0.
- R4: Indices 0x01 to 0x04 are filter registers that store and read back all 24 bits.
- R5: For index 0x52 (copy control), bit 11 is stored as the clear flag. The flag drives `clr_en` and reads back at bit 11. All other bits of 0x52 read 0, including the start bits 13:12.
- R6: A write to 0x52 with bits 13:12 both 1 gives exactly one `start_pulse` cycle, in the cycle after the register update. A write with only one of those bits set gives no pulse.
- R7: A byte other than 0x61 accepted while idle raises `err_unknown` for the next cycle only and is otherwise dropped. A following valid command still works.
- R8: The four word bytes of a command are data even when they equal 0x61. They raise no error.
- R9: If the start request arrives while `eng_busy` is 1, `start_pulse` stays 0 and `in_ready` stays 0 until `eng_busy` falls. In that cycle `start_pulse` is 1 and `in_ready` returns to 1.
- R10: A write to an index outside the set named in R3 to R5 changes no register, and such an index reads 0.
- R11: Cycles with `in_valid` low between the bytes of a command do not disturb the collection of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Command byte present |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Decoder can take a byte this cycle |
| eng_busy | input | 1 | Copy engine cannot accept a start yet |
| start_pulse | output | 1 | One-cycle copy start request |
| clr_en | output | 1 | Stored clear-enable flag |
| err_unknown | output | 1 | One-cycle flag for a dropped unrecognised byte |
| rd_idx | input | 8 | Readback register index |
| rd_data | output | 24 | Readback value of the indexed register |

## Verification
The assertions check the following on every cycle:
- a write strobe never lasts two cycles;
- an error flag always follows an accepted byte;
- a start pulse never coincides with a busy engine and never repeats;
- a pending start survives while the engine stays busy;
- a stride write always lands in the stride register.

Some behaviour only the bench scenarios can show. This covers the index-to-register mapping and the field masking on readback. It also covers the filter reset pattern, the split between start patterns that fire and those that do not, and opcode-valued data bytes that must not raise errors. Finally it covers the stall-and-release sequence against the busy input.

// File: rtl/cmd_regdec_pkg.sv
package cmd_regdec_pkg;

  localparam logic [7:0] OP_LOAD        = 8'h61;
  localparam logic [7:0] IDX_SRC_ORG    = 8'h49;
  localparam logic [7:0] IDX_SRC_SIZE   = 8'h4A;
  localparam logic [7:0] IDX_DST_ADDR   = 8'h4B;
  localparam logic [7:0] IDX_DST_STRIDE = 8'h4D;
  localparam logic [7:0] IDX_COPY_CTL   = 8'h52;

  typedef enum logic {
    PS_IDLE    = 1'b0,
    PS_COLLECT = 1'b1
  } pstate_e;

endpackage

// File: rtl/cmd_parser.sv
module cmd_parser
  import cmd_regdec_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 4,
  localparam int WORD_W    = BYTE_W * WORD_BYTES,
  localparam int CNT_W     = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_fire,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              wr_stb,
  output logic [WORD_W-1:0] wr_word,
  output logic              err
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_BYTES - 1);

  pstate_e           state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] shift_q, shift_d;
  logic              stb_q, stb_d;
  logic              err_q, err_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    stb_d   = 1'b0;
    err_d   = 1'b0;
    if (byte_fire) begin
      unique case (state_q)
        PS_IDLE: begin
          if (byte_in == OP_LOAD[BYTE_W-1:0]) begin
            state_d = PS_COLLECT;
            cnt_d   = '0;
          end else begin
            err_d = 1'b1;
          end
        end
        PS_COLLECT: begin
          shift_d = {shift_q[WORD_W-BYTE_W-1:0], byte_in};
          if (cnt_q == CNT_LAST) begin
            state_d = PS_IDLE;
            stb_d   = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      stb_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      stb_q   <= stb_d;
      err_q   <= err_d;
    end
  end

  assign wr_stb  = stb_q;
  assign wr_word = shift_q;
  assign err     = err_q;

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R2
  AST_ERR_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(byte_fire)); // R7

endmodule

// File: rtl/cmd_regfile.sv
module cmd_regfile
  import cmd_regdec_pkg::*;
#(
  parameter int               IDX_W      = 8,
  parameter int               DATA_W     = 24,
  parameter int               NUM_FILT   = 4,
  parameter int               FILT_BASE  = 1,
  parameter logic [DATA_W-1:0] FILT_RESET = 24'h666666,
  parameter int               STRIDE_W   = 10,
  parameter int               CLR_BIT    = 11,
  parameter int               START_LO   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              clr_en,
  output logic              start_req
);

  logic [DATA_W-1:0]   org_q, org_d;
  logic [DATA_W-1:0]   size_q, size_d;
  logic [DATA_W-1:0]   addr_q, addr_d;
  logic [STRIDE_W-1:0] stride_q, stride_d;
  logic                clr_q, clr_d;
  logic [DATA_W-1:0]   filt_q [NUM_FILT];
  logic [DATA_W-1:0]   filt_d [NUM_FILT];
  logic [NUM_FILT-1:0] filt_hit;

  for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt_hit
    assign filt_hit[g] = wr_stb && (wr_idx == IDX_W'(FILT_BASE + g));
  end

  always_comb begin
    org_d    = org_q;
    size_d   = size_q;
    addr_d   = addr_q;
    stride_d = stride_q;
    clr_d    = clr_q;
    if (wr_stb) begin
      if (wr_idx == IDX_SRC_ORG)    org_d    = wr_data;
      if (wr_idx == IDX_SRC_SIZE)   size_d   = wr_data;
      if (wr_idx == IDX_DST_ADDR)   addr_d   = wr_data;
      if (wr_idx == IDX_DST_STRIDE) stride_d = wr_data[STRIDE_W-1:0];
      if (wr_idx == IDX_COPY_CTL)   clr_d    = wr_data[CLR_BIT];
    end
    for (int i = 0; i < NUM_FILT; i++) begin
      filt_d[i] = filt_hit[i] ? wr_data : filt_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      org_q    <= '0;
      size_q   <= '0;
      addr_q   <= '0;
      stride_q <= '0;
      clr_q    <= 1'b0;
      for (int i = 0; i < NUM_FILT; i++) filt_q[i] <= FILT_RESET;
    end else begin
      org_q    <= org_d;
      size_q   <= size_d;
      addr_q   <= addr_d;
      stride_q <= stride_d;
      clr_q    <= clr_d;
      for (int i = 0; i < NUM_FILT; i++) filt_q[i] <= filt_d[i];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_idx == IDX_SRC_ORG)    rd_data = org_q;
    if (rd_idx == IDX_SRC_SIZE)   rd_data = size_q;
    if (rd_idx == IDX_DST_ADDR)   rd_data = addr_q;
    if (rd_idx == IDX_DST_STRIDE) rd_data = DATA_W'(stride_q);
    if (rd_idx == IDX_COPY_CTL)   rd_data[CLR_BIT] = clr_q;
    for (int i = 0; i < NUM_FILT; i++) begin
      if (rd_idx == IDX_W'(FILT_BASE + i)) rd_data = filt_q[i];
    end
  end

  assign clr_en    = clr_q;
  assign start_req = wr_stb && (wr_idx == IDX_COPY_CTL)
                   && wr_data[START_LO] && wr_data[START_LO+1];

  AST_STRIDE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_idx == IDX_DST_STRIDE) |=> stride_q == $past(wr_data[STRIDE_W-1:0])); // R3

endmodule

// File: rtl/cmd_start_ctl.sv
module cmd_start_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic eng_busy,
  output logic start_pulse,
  output logic stall
);

  logic pend_q, pend_d;

  always_comb begin
    pend_d = start_req || (pend_q && eng_busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign start_pulse = pend_q && !eng_busy;
  assign stall       = pend_q && eng_busy;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R6
  AST_PULSE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !eng_busy); // R9
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && eng_busy) |=> pend_q); // R9

endmodule

// File: rtl/cmd_regdec.sv
module cmd_regdec
  import cmd_regdec_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 4,
  parameter int NUM_FILT   = 4,
  parameter int STRIDE_W   = 10,
  localparam int WORD_W    = BYTE_W * WORD_BYTES,
  localparam int IDX_W     = BYTE_W,
  localparam int DATA_W    = WORD_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  input  logic              eng_busy,
  output logic              start_pulse,
  output logic              clr_en,
  output logic              err_unknown,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic rst_m_q, rst_s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic              byte_fire;
  logic              wr_stb;
  logic [WORD_W-1:0] wr_word;
  logic              start_req;
  logic              stall;

  assign in_ready  = !stall;
  assign byte_fire = in_valid && in_ready;

  cmd_parser #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_parser (
    .clk       (clk),
    .rst_n     (rst_s_q),
    .byte_fire (byte_fire),
    .byte_in   (in_data),
    .wr_stb    (wr_stb),
    .wr_word   (wr_word),
    .err       (err_unknown)
  );

  cmd_regfile #(
    .IDX_W    (IDX_W),
    .DATA_W   (DATA_W),
    .NUM_FILT (NUM_FILT),
    .STRIDE_W (STRIDE_W)
  ) u_regfile (
    .clk       (clk),
    .rst_n     (rst_s_q),
    .wr_stb    (wr_stb),
    .wr_idx    (wr_word[WORD_W-1 -: IDX_W]),
    .wr_data   (wr_word[DATA_W-1:0]),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .clr_en    (clr_en),
    .start_req (start_req)
  );

  cmd_start_ctl u_start (
    .clk         (clk),
    .rst_n       (rst_s_q),
    .start_req   (start_req),
    .eng_busy    (eng_busy),
    .start_pulse (start_pulse),
    .stall       (stall)
  );

  AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_s_q)
    !in_ready |-> eng_busy); // R9

endmodule

// File: tb/cmd_regdec_tb.sv
module cmd_regdec_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_ready;
  logic        eng_busy;
  logic        start_pulse;
  logic        clr_en;
  logic        err_unknown;
  logic [7:0]  rd_idx;
  logic [23:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  cmd_regdec u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .eng_busy(eng_busy), .start_pulse(start_pulse),
    .clr_en(clr_en), .err_unknown(err_unknown), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // {index, value written, expected readback}
  localparam logic [55:0] VEC [10] = '{
    {8'h49, 24'h123456, 24'h123456},  // R3
    {8'h4A, 24'hABCDEF, 24'hABCDEF},  // R3
    {8'h4B, 24'h800001, 24'h800001},  // R3
    {8'h4D, 24'hFFFFFF, 24'h0003FF},  // R3
    {8'h01, 24'h000001, 24'h000001},  // R4
    {8'h04, 24'hFEDCBA, 24'hFEDCBA},  // R4
    {8'h52, 24'h000800, 24'h000800},  // R5
    {8'h52, 24'hFFC7FF, 24'h000000},  // R5
    {8'h60, 24'hABCDEF, 24'h000000},  // R10
    {8'h02, 24'h000061, 24'h000061}   // R8
  };

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] idx, input logic [23:0] val, input int gap);
    send_byte(8'h61, gap);
    send_byte(idx, gap);
    send_byte(val[23:16], gap);
    send_byte(val[15:8], gap);
    send_byte(val[7:0], 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      summary();
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = 8'h00;
    eng_busy = 1'b0;
    rd_idx   = 8'h01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 1; i <= 4; i++) begin
      rd_idx = 8'(i);
      #1 check("R1 filter reset", rd_data, 24'h666666);
    end
    rd_idx = 8'h49;
    #1 check("R1 origin reset", rd_data, 24'h0);
    rd_idx = 8'h4D;
    #1 check("R1 stride reset", rd_data, 24'h0);
    check("R1 ready", {23'b0, in_ready}, 24'h1);
    check("R1 outputs low", {21'b0, start_pulse, err_unknown, clr_en}, 24'h0);

    // R2 table of writes and readbacks
    for (int v = 0; v < 10; v++) begin
      send_cmd(VEC[v][55:48], VEC[v][47:24], 0);
      check("R8 no error on data bytes", {23'b0, err_unknown}, 24'h0);
      @(negedge clk);
      rd_idx = VEC[v][55:48];
      #1 check("R2 table readback", rd_data, VEC[v][23:0]);
      check("R6 no pulse in table", {23'b0, start_pulse}, 24'h0);
    end

    // R10: 0x60 write touched no mapped register
    rd_idx = 8'h49;
    #1 check("R10 origin untouched", rd_data, 24'h123456);
    rd_idx = 8'h03;
    #1 check("R10 filter untouched", rd_data, 24'h666666);

    // R8: index byte and data bytes all 0x61
    send_cmd(8'h61, 24'h616161, 0);
    check("R8 opcode-valued data", {23'b0, err_unknown}, 24'h0);
    @(negedge clk);
    rd_idx = 8'h61;
    #1 check("R8 unmapped readback", rd_data, 24'h0);

    // R5 clear flag
    send_cmd(8'h52, 24'h000800, 0);
    @(negedge clk);
    check("R5 clr_en set", {23'b0, clr_en}, 24'h1);

    // R7 unknown bytes then a valid command
    send_byte(8'h33, 0);
    check("R7 error raised", {23'b0, err_unknown}, 24'h1);
    @(negedge clk);
    check("R7 error one cycle", {23'b0, err_unknown}, 24'h0);
    send_cmd(8'h02, 24'h0A0B0C, 0);
    @(negedge clk);
    rd_idx = 8'h02;
    #1 check("R7 command after error", rd_data, 24'h0A0B0C);

    // R11 gaps between bytes
    send_cmd(8'h03, 24'h13579B, 3);
    @(negedge clk);
    rd_idx = 8'h03;
    #1 check("R11 gapped command", rd_data, 24'h13579B);

    // R6 single start bit: no pulse
    send_cmd(8'h52, 24'h002000, 0);
    @(negedge clk);
    check("R6 one start bit", {23'b0, start_pulse}, 24'h0);
    @(negedge clk);
    check("R6 one start bit later", {23'b0, start_pulse}, 24'h0);

    // R6 both start bits
    send_cmd(8'h52, 24'h003800, 0);
    @(negedge clk);
    check("R6 start pulse", {23'b0, start_pulse}, 24'h1);
    rd_idx = 8'h52;
    #1 check("R5 start bits read zero", rd_data, 24'h000800);
    @(negedge clk);
    check("R6 pulse one cycle", {23'b0, start_pulse}, 24'h0);

    // R9 stall while engine busy
    eng_busy = 1'b1;
    send_cmd(8'h52, 24'h003000, 0);
    @(negedge clk);
    check("R9 no pulse while busy", {23'b0, start_pulse}, 24'h0);
    check("R9 ready low", {23'b0, in_ready}, 24'h0);
    repeat (3) @(negedge clk);
    check("R9 still stalled", {23'b0, in_ready}, 24'h0);
    eng_busy = 1'b0;
    #1 check("R9 pulse on release", {23'b0, start_pulse}, 24'h1);
    check("R9 ready back", {23'b0, in_ready}, 24'h1);
    @(negedge clk);
    check("R9 pulse ends", {23'b0, start_pulse}, 24'h0);
    check("R5 clear flag cleared", {23'b0, clr_en}, 24'h0);

    summary();
  end

endmodule